// File: doc/BRIEF.md
# Trap Return State Unit

This unit carries out the two trap-return operations of a small RISC-V style core: the return from a machine-level trap and the return from a supervisor-level trap. The core presents a return request for one cycle. With it come the kind of return, the current privilege level, the virtualization flag, the interrupt-stack fields of the status register, the trap-control bits, the saved exception PCs and the feature enables for compressed instructions, the hypervisor extension and physical memory protection.

The unit first runs a fixed sequence of legality checks. Only the first failing check is reported. If a check fails, the unit raises an exception with a cause code and all of its held state stays as it was. If the request is legal, the unit pops the interrupt-enable and previous-privilege stack. It then presents the new privilege, the new virtualization flag, the updated status fields and the redirect PC, all registered.

The outcome appears one clock after the request. The request is a plain one-cycle strobe with no back-pressure. A new request may be issued on every cycle, and each one produces exactly one outcome on the next cycle. The status and state outputs hold their values between legal returns.

Top module: `trapret_unit`

## Requirements
- R1: After reset, `done`, `redirect_valid` and `exc_valid` are 0, `redirect_pc` is 0, `new_priv` is machine (3), and every other state output is 0. Privilege encoding: user=0, supervisor=1, machine=3.
- R2: A supervisor return (`req_sret`=1) issued at user privilege (0) raises cause 2 (illegal instruction).
- R3: When `has_c` is 0 and bits [1:0] of the selected exception PC (`sepc` for a supervisor return, `mepc` for a machine return) are not both 0, cause 0 (misaligned fetch) is raised and no return takes place.
- R4: A supervisor return with `st_tsr`=1 at a privilege other than machine raises cause 2.
- R5: A supervisor return raises cause 22 (virtual-instruction fault) when `has_h`=1, `cur_virt`=1 and `hs_vtsr`=1.
- R6: A legal supervisor return with `has_h`=1 and `cur_virt`=0 has the following effects:
  - `new_priv` = {0, `st_spp`} and `new_virt` = `hs_spv`.
  - `new_spv`=0, `new_spp`=0, `new_sie`=`st_spie` and `new_spie`=1.
  - The machine fields pass through unchanged.
- R7: Any other legal supervisor return has the following effects:
  - `new_priv` = {0, `st_spp`}, `new_sie`=`st_spie`, `new_spie`=1 and `new_spp`=0.
  - `new_virt`=`cur_virt` and `new_spv`=`hs_spv`.
  - `redirect_pc`=`sepc`.
- R8: A machine return (`req_sret`=0) at a privilege other than machine raises cause 2.
- R9: A machine return raises cause 2 when `has_pmp`=1, `pmp_rule_cnt`=0 and `st_mpp` is not 3.
- R10: A legal machine return has the following effects:
  - `new_priv`=`st_mpp`, `new_mie`=`st_mpie`, `new_mpie`=1, `new_mpp`=0 and `new_mpv`=0.
  - `new_virt`=`st_mpv` if `has_h`=1, and `cur_virt` otherwise.
  - The supervisor fields pass through, `new_spv`=`hs_spv`, and `redirect_pc`=`mepc`.
- R11: `done` pulses in the cycle after each request, with exactly one of `redirect_valid` or `exc_valid` set. With no request, all three are 0.
- R12: A failing request leaves `redirect_pc` and every state output unchanged.
- R13: The checks run in a fixed order, and only the first failing one is reported.
  - Supervisor return: privilege, then alignment, then the trap bit, then the virtual trap bit.
  - Machine return: privilege, then alignment, then protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle return request |
| req_sret | input | 1 | 1 = supervisor return, 0 = machine return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization flag |
| st_tsr | input | 1 | Trap supervisor returns below machine level |
| hs_spv | input | 1 | Hypervisor previous virtualization flag |
| hs_vtsr | input | 1 | Trap supervisor returns while virtualized |
| sepc | input | XLEN | Supervisor exception PC |
| mepc | input | XLEN | Machine exception PC |
| has_c | input | 1 | Compressed instructions supported |
| has_h | input | 1 | Hypervisor extension present |
| has_pmp | input | 1 | Memory protection supported |
| pmp_rule_cnt | input | PMP_CNT_W | Number of configured protection rules |
| done | output | 1 | Outcome strobe, one cycle after the request |
| redirect_valid | output | 1 | Legal return, fetch from redirect_pc |
| redirect_pc | output | XLEN | Return target |
| exc_valid | output | 1 | Request failed a check |
| exc_cause | output | 5 | Cause code: 0, 2 or 22 |
| new_priv | output | 2 | Privilege after the last legal return |
| new_virt | output | 1 | Virtualization flag after the last legal return |
| new_sie | output | 1 | Updated supervisor interrupt enable |
| new_spie | output | 1 | Updated supervisor previous interrupt enable |
| new_spp | output | 1 | Updated supervisor previous privilege |
| new_mie | output | 1 | Updated machine interrupt enable |
| new_mpie | output | 1 | Updated machine previous interrupt enable |
| new_mpp | output | 2 | Updated machine previous privilege |
| new_mpv | output | 1 | Updated machine previous virtualization flag |
| new_spv | output | 1 | Updated hypervisor previous virtualization flag |

## Verification
A wrong check order or a missing check shows up as a wrong `exc_cause` or a spurious `redirect_valid` on the very next cycle. The random stimulus often makes several checks fail at once, so order faults are exposed quickly. A faulty stack pop or a wrong commit gate shows up in the `new_*` outputs one cycle after the request. Because those outputs hold their values, a bad commit on a failing request stays visible until the next legal return overwrites it, and the cycle-by-cycle comparison catches it at once.

// File: rtl/trapret_pkg.sv
package trapret_pkg;
  localparam logic [1:0] PRV_USER = 2'd0;
  localparam logic [1:0] PRV_SUP  = 2'd1;
  localparam logic [1:0] PRV_MACH = 2'd3;

  typedef logic [4:0] cause_t;
  localparam cause_t CAUSE_MISALIGN = 5'd0;
  localparam cause_t CAUSE_ILLEGAL  = 5'd2;
  localparam cause_t CAUSE_VIRT     = 5'd22;

  typedef struct packed {
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       mpv;
    logic       spv;
  } stack_t;
endpackage

// File: rtl/trapret_legal.sv
module trapret_legal
  import trapret_pkg::*;
(
  input  logic       is_sret,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       tsr,
  input  logic       vtsr,
  input  logic [1:0] mpp,
  input  logic [1:0] epc_lo,
  input  logic       has_c,
  input  logic       has_h,
  input  logic       has_pmp,
  input  logic       pmp_zero,
  output logic       fail,
  output cause_t     cause
);
  logic misaligned;
  assign misaligned = !has_c && (epc_lo != 2'b00);

  // First failing check wins; later checks are masked by the else chain.
  always_comb begin
    fail  = 1'b0;
    cause = CAUSE_MISALIGN;
    if (is_sret) begin
      if (priv < PRV_SUP) begin
        fail = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fail = 1'b1; cause = CAUSE_MISALIGN;
      end else if (tsr && priv != PRV_MACH) begin
        fail = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (has_h && virt && vtsr) begin
        fail = 1'b1; cause = CAUSE_VIRT;
      end
    end else begin
      if (priv != PRV_MACH) begin
        fail = 1'b1; cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fail = 1'b1; cause = CAUSE_MISALIGN;
      end else if (has_pmp && pmp_zero && mpp != PRV_MACH) begin
        fail = 1'b1; cause = CAUSE_ILLEGAL;
      end
    end
  end
endmodule

// File: rtl/trapret_pop.sv
module trapret_pop
  import trapret_pkg::*;
(
  input  logic       is_sret,
  input  logic       virt,
  input  logic       has_h,
  input  stack_t     cur,
  output logic [1:0] nxt_priv,
  output logic       nxt_virt,
  output stack_t     nxt
);
  always_comb begin
    nxt      = cur;
    nxt_virt = virt;
    if (is_sret) begin
      nxt_priv = {1'b0, cur.spp};
      nxt.sie  = cur.spie;
      nxt.spie = 1'b1;
      nxt.spp  = 1'b0;
      if (has_h && !virt) begin
        nxt_virt = cur.spv;
        nxt.spv  = 1'b0;
      end
    end else begin
      nxt_priv = cur.mpp;
      nxt.mie  = cur.mpie;
      nxt.mpie = 1'b1;
      nxt.mpp  = PRV_USER;
      nxt.mpv  = 1'b0;
      if (has_h) nxt_virt = cur.mpv;
    end
  end
endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int PMP_CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_sret,
  input  logic [1:0]           cur_priv,
  input  logic                 cur_virt,
  input  logic                 st_sie,
  input  logic                 st_spie,
  input  logic                 st_spp,
  input  logic                 st_mie,
  input  logic                 st_mpie,
  input  logic [1:0]           st_mpp,
  input  logic                 st_mpv,
  input  logic                 st_tsr,
  input  logic                 hs_spv,
  input  logic                 hs_vtsr,
  input  logic [XLEN-1:0]      sepc,
  input  logic [XLEN-1:0]      mepc,
  input  logic                 has_c,
  input  logic                 has_h,
  input  logic                 has_pmp,
  input  logic [PMP_CNT_W-1:0] pmp_rule_cnt,
  output logic                 done,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_pc,
  output logic                 exc_valid,
  output logic [4:0]           exc_cause,
  output logic [1:0]           new_priv,
  output logic                 new_virt,
  output logic                 new_sie,
  output logic                 new_spie,
  output logic                 new_spp,
  output logic                 new_mie,
  output logic                 new_mpie,
  output logic [1:0]           new_mpp,
  output logic                 new_mpv,
  output logic                 new_spv
);
  logic [XLEN-1:0] epc_sel;
  logic            pmp_zero;
  logic            chk_fail;
  cause_t          chk_cause;
  stack_t          cur_stack, pop_stack, held_stack;
  logic [1:0]      pop_priv, held_priv;
  logic            pop_virt, held_virt;

  assign epc_sel  = req_sret ? sepc : mepc;
  assign pmp_zero = (pmp_rule_cnt == '0);
  assign cur_stack = '{sie: st_sie, spie: st_spie, spp: st_spp, mie: st_mie,
                       mpie: st_mpie, mpp: st_mpp, mpv: st_mpv, spv: hs_spv};

  trapret_legal u_legal (
    .is_sret (req_sret),
    .priv    (cur_priv),
    .virt    (cur_virt),
    .tsr     (st_tsr),
    .vtsr    (hs_vtsr),
    .mpp     (st_mpp),
    .epc_lo  (epc_sel[1:0]),
    .has_c   (has_c),
    .has_h   (has_h),
    .has_pmp (has_pmp),
    .pmp_zero(pmp_zero),
    .fail    (chk_fail),
    .cause   (chk_cause)
  );

  trapret_pop u_pop (
    .is_sret (req_sret),
    .virt    (cur_virt),
    .has_h   (has_h),
    .cur     (cur_stack),
    .nxt_priv(pop_priv),
    .nxt_virt(pop_virt),
    .nxt     (pop_stack)
  );

  // Outcome strobes and cause
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done           <= 1'b0;
      redirect_valid <= 1'b0;
      exc_valid      <= 1'b0;
      exc_cause      <= '0;
    end else begin
      done           <= req_valid;
      redirect_valid <= req_valid && !chk_fail;
      exc_valid      <= req_valid && chk_fail;
      if (req_valid && chk_fail) exc_cause <= chk_cause;
    end
  end

  // Architectural results commit only on a legal request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_pc <= '0;
      held_priv   <= PRV_MACH;
      held_virt   <= 1'b0;
      held_stack  <= '0;
    end else if (req_valid && !chk_fail) begin
      redirect_pc <= epc_sel;
      held_priv   <= pop_priv;
      held_virt   <= pop_virt;
      held_stack  <= pop_stack;
    end
  end

  assign new_priv = held_priv;
  assign new_virt = held_virt;
  assign new_sie  = held_stack.sie;
  assign new_spie = held_stack.spie;
  assign new_spp  = held_stack.spp;
  assign new_mie  = held_stack.mie;
  assign new_mpie = held_stack.mpie;
  assign new_mpp  = held_stack.mpp;
  assign new_mpv  = held_stack.mpv;
  assign new_spv  = held_stack.spv;
endmodule

// File: rtl/trapret_unit_chk.sv
module trapret_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_sret,
  input logic [1:0]      cur_priv,
  input logic            has_c,
  input logic            done,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            exc_valid,
  input logic [4:0]      exc_cause,
  input logic [1:0]      new_priv,
  input logic            new_virt,
  input logic            new_spie,
  input logic            new_spp,
  input logic            new_mpie,
  input logic [1:0]      new_mpp,
  input logic            new_mpv
);
  assert_done_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({redirect_valid, exc_valid}) == 1);

  assert_no_outcome_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !redirect_valid && !exc_valid);

  assert_fail_holds_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $stable(new_priv) && $stable(new_virt) && $stable(redirect_pc));

  assert_cause_known_R13: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == 5'd0 || exc_cause == 5'd2 || exc_cause == 5'd22));

  assert_user_sret_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sret && cur_priv == 2'd0 |=> exc_valid && exc_cause == 5'd2);

  assert_aligned_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !has_c |=> !redirect_valid || redirect_pc[1:0] == 2'b00);

  assert_mret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_sret |=> !redirect_valid || (new_mpie && new_mpp == 2'd0 && !new_mpv));

  assert_sret_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_sret |=> !redirect_valid || (new_spie && !new_spp));
endmodule

bind trapret_unit trapret_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trapret_unit_tb.sv
module trapret_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int PMP_CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_sret = 0, cur_virt = 0;
  logic [1:0] cur_priv = 2'd3, st_mpp = 0;
  logic st_sie = 0, st_spie = 0, st_spp = 0, st_mie = 0, st_mpie = 0, st_mpv = 0;
  logic st_tsr = 0, hs_spv = 0, hs_vtsr = 0, has_c = 1, has_h = 0, has_pmp = 0;
  logic [XLEN-1:0] sepc = 0, mepc = 0;
  logic [PMP_CNT_W-1:0] pmp_rule_cnt = 0;
  logic done, redirect_valid, exc_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [4:0] exc_cause;
  logic [1:0] new_priv, new_mpp;
  logic new_virt, new_sie, new_spie, new_spp, new_mie, new_mpie, new_mpv, new_spv;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  // model of held state: {priv,virt,sie,spie,spp,mie,mpie,mpp,mpv,spv}
  logic [11:0] m_state;
  logic [XLEN-1:0] m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  trapret_unit #(.XLEN(XLEN), .PMP_CNT_W(PMP_CNT_W)) u_dut (.*);

  function automatic logic [11:0] dut_state();
    return {new_priv, new_virt, new_sie, new_spie, new_spp, new_mie, new_mpie,
            new_mpp, new_mpv, new_spv};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic defaults();
    req_sret = 0; cur_priv = 2'd3; cur_virt = 0;
    st_sie = 0; st_spie = 0; st_spp = 0; st_mie = 0; st_mpie = 0; st_mpp = 0; st_mpv = 0;
    st_tsr = 0; hs_spv = 0; hs_vtsr = 0; has_c = 1; has_h = 0; has_pmp = 0;
    pmp_rule_cnt = 5'd4; sepc = 32'h0000_1000; mepc = 32'h0000_2000;
  endtask

  // Drives one request from the current inputs and checks the outcome.
  task automatic run(string force_tag);
    bit e_fail; logic [4:0] e_cause; string tag;
    logic [11:0] e_state; logic [XLEN-1:0] epc; bit mis;
    logic [1:0] np; logic nv, sie, spie, spp, mie, mpie, mpv, spv; logic [1:0] mpp;
    epc = req_sret ? sepc : mepc;
    mis = !has_c && epc[1:0] != 2'b00;
    e_fail = 1; e_cause = 5'd2;
    if (req_sret) begin
      if (cur_priv == 2'd0) tag = "R2";
      else if (mis) begin tag = "R3"; e_cause = 5'd0; end
      else if (st_tsr && cur_priv != 2'd3) tag = "R4";
      else if (has_h && cur_virt && hs_vtsr) begin tag = "R5"; e_cause = 5'd22; end
      else begin e_fail = 0; tag = (has_h && !cur_virt) ? "R6" : "R7"; end
    end else begin
      if (cur_priv != 2'd3) tag = "R8";
      else if (mis) begin tag = "R3"; e_cause = 5'd0; end
      else if (has_pmp && pmp_rule_cnt == 0 && st_mpp != 2'd3) tag = "R9";
      else begin e_fail = 0; tag = "R10"; end
    end
    if (force_tag != "") tag = force_tag;
    np = cur_priv; nv = cur_virt; sie = st_sie; spie = st_spie; spp = st_spp;
    mie = st_mie; mpie = st_mpie; mpp = st_mpp; mpv = st_mpv; spv = hs_spv;
    if (req_sret) begin
      np = {1'b0, st_spp}; sie = st_spie; spie = 1; spp = 0;
      if (has_h && !cur_virt) begin nv = hs_spv; spv = 0; end
    end else begin
      np = st_mpp; mie = st_mpie; mpie = 1; mpp = 0; mpv = 0;
      if (has_h) nv = st_mpv;
    end
    e_state = {np, nv, sie, spie, spp, mie, mpie, mpp, mpv, spv};
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(done == 1, "R11", "done", done, 1);
    chk(exc_valid == e_fail && redirect_valid == !e_fail, tag, "outcome",
        {exc_valid, redirect_valid}, {e_fail, !e_fail});
    if (e_fail) begin
      chk(exc_cause == e_cause, tag, "cause", exc_cause, e_cause);
      chk(dut_state() == m_state && redirect_pc == m_pc, "R12", "held state",
          {dut_state(), redirect_pc}, {m_state, m_pc});
    end else begin
      m_state = e_state; m_pc = epc;
      chk(dut_state() == e_state, tag, "state", dut_state(), e_state);
      chk(redirect_pc == epc, tag, "pc", redirect_pc, epc);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(!done && !redirect_valid && !exc_valid, "R11", "idle strobes",
        {done, redirect_valid, exc_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    m_state = {2'd3, 10'd0}; m_pc = '0;
    repeat (3) @(negedge clk);
    chk(!done && !redirect_valid && !exc_valid && exc_cause == 0, "R1", "reset strobes",
        {done, redirect_valid, exc_valid}, 0);
    chk(dut_state() == m_state && redirect_pc == 0, "R1", "reset state",
        dut_state(), m_state);
    rst_n = 1;
    @(negedge clk);

    // R2 and R13: user SRET beats misalignment
    defaults(); req_sret = 1; cur_priv = 0; run("");
    defaults(); req_sret = 1; cur_priv = 0; has_c = 0; sepc = 32'h13; run("R13");
    // R8, R13: MRET from supervisor with misaligned target
    defaults(); cur_priv = 1; has_c = 0; mepc = 32'h22; run("R13");
    // R3
    defaults(); req_sret = 1; cur_priv = 1; has_c = 0; sepc = 32'h102; run("");
    defaults(); req_sret = 1; cur_priv = 1; has_c = 1; sepc = 32'h102; st_spie = 1; run("R7");
    defaults(); has_c = 0; mepc = 32'h201; run("");
    // R13: misalign beats trap bit
    defaults(); req_sret = 1; cur_priv = 1; has_c = 0; sepc = 32'h1; st_tsr = 1; run("R13");
    // R4
    defaults(); req_sret = 1; cur_priv = 1; st_tsr = 1; run("");
    defaults(); req_sret = 1; cur_priv = 3; st_tsr = 1; st_spp = 1; run("R7");
    // R5, R13
    defaults(); req_sret = 1; cur_priv = 1; has_h = 1; cur_virt = 1; hs_vtsr = 1; run("");
    defaults(); req_sret = 1; cur_priv = 1; has_h = 1; cur_virt = 1; hs_vtsr = 1; st_tsr = 1; run("R13");
    // R6
    defaults(); req_sret = 1; cur_priv = 1; has_h = 1; hs_spv = 1; st_spp = 1; st_sie = 1; run("");
    idle_check();
    // R9
    defaults(); has_pmp = 1; pmp_rule_cnt = 0; st_mpp = 1; run("");
    defaults(); has_pmp = 1; pmp_rule_cnt = 0; st_mpp = 3; st_mpie = 1; run("R10");
    defaults(); has_pmp = 0; pmp_rule_cnt = 0; st_mpp = 0; run("R10");
    // R10 with hypervisor previous virtualization
    defaults(); has_h = 1; st_mpv = 1; st_mpp = 1; st_mpie = 1; run("");
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [1:0] pr;
      req_sret = $urandom % 2;
      pr = 2'($urandom % 4);
      cur_priv = (pr == 2'd2) ? 2'd3 : pr;
      cur_virt = $urandom % 2;
      {st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, hs_spv} = 7'($urandom);
      st_mpp = 2'($urandom % 4);
      st_tsr = ($urandom % 4) == 0;
      hs_vtsr = $urandom % 2;
      has_c = $urandom % 2; has_h = $urandom % 2; has_pmp = $urandom % 2;
      pmp_rule_cnt = 5'($urandom % 4);
      sepc = $urandom; mepc = $urandom;
      if ($urandom % 2) begin sepc[1:0] = 0; mepc[1:0] = 0; end
      run("");
      if ((i % 37) == 0) idle_check();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule